// File: doc/BRIEF.md
# Four-Tap Pattern-Match Correlator, Plain and Retimed

The block watches a stream of samples, one per clock, and reports how many of the four most recent samples equal their programmed reference values. Slot 0 of the reference vector is compared with the newest sample, and slots 1 to 3 are compared with progressively older ones. The count from 0 to 4 comes out of a register.

Two structures are built side by side and driven from the same input and reference bank. The plain structure keeps every sample register in a four-deep shift line, with the comparators and the three-adder chain purely combinational after it. The retimed structure moves some of those registers forward into the comparator and adder network using the lag set a=-1, b=-1, c=-2, d=-2 for the comparators, -2, -1, 0 for the adders and 0 for the interface. In a unit model where a comparator costs 3 and an adder 7, this cuts the longest register-to-register path from 24 to 13. The retimed registers start from the values that match the plain shift line holding zero samples, so both counts agree from the first cycle after reset.

Top module: `corr_pair`

## Requirements
- R1: On every rising edge with `rst` high, both `count_plain` and `count_retimed` become 0 after that edge.
- R2: After a rising edge with `rst` low, `count_plain` equals the number of k in 0..3 for which the sample taken k+1 edges earlier equals reference slot k. Slot k is `ref_in[k*W +: W]` as captured during reset.
- R3: A sample position that reaches back to an edge at or before the last reset edge is treated as the value 0. The first four counts after release therefore include taps whose reference slot is 0.
- R4: After every rising edge with `rst` low, `count_retimed` equals `count_plain`.
- R5: Each count stays within 0..4. It reads 4 when all four taps match and 0 when none match.
- R6: `ref_in` is captured on rising edges with `rst` high. Changes to `ref_in` while `rst` is low have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also loads the references |
| sample_in | input | W | One data sample per cycle |
| ref_in | input | 4*W | Four reference values, slot k at bits k*W +: W |
| count_plain | output | 3 | Registered match count from the plain structure |
| count_retimed | output | 3 | Registered match count from the retimed structure |

## Verification
The assertions assume that the design is in reset at the first clock edge. They also assume that references reach the structures only through the capture bank, so that the retimed start-up values and the pipelined match bits agree with the stored slots. The stimulus holds `rst` high for several edges at the start, before any check. It then scrambles `ref_in` after release to show that the bank ignores it. Samples are always known values, drawn half the time from the reference set so that partial and full matches occur often. A second reset with all-zero references exercises the zero-history start.

// File: rtl/corr_pkg.sv
package corr_pkg;
  localparam int TAPS  = 4;
  localparam int CNT_W = $clog2(TAPS + 1);
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/corr_eq.sv
// Equality comparator of one tap: unit delay 3 in the timing model.
module corr_eq #(
  parameter int W = 8
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] ref_val,
  output logic         hit
);
  assign hit = (smp == ref_val);
endmodule

// File: rtl/corr_add.sv
// Count adder node: unit delay 7 in the timing model.
module corr_add
  import corr_pkg::*;
(
  input  cnt_t a,
  input  cnt_t b,
  output cnt_t s
);
  assign s = a + b;
endmodule

// File: rtl/corr_ref_bank.sv
// Holds the reference slots; loads only while reset is high.
module corr_ref_bank
  import corr_pkg::*;
#(
  parameter int W = 8,
  localparam int RW = TAPS * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ref_in,
  output logic [RW-1:0] ref_q
);
  always_ff @(posedge clk) begin
    if (rst) ref_q <= ref_in;
  end

  // R6: stored references never move outside reset.
  a_r6_refs_frozen: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(ref_q));
endmodule

// File: rtl/corr_plain.sv
// Reference structure: shift line of four sample registers, then combinational
// comparators and a three-adder chain (oldest tap enters first), output register.
module corr_plain
  import corr_pkg::*;
#(
  parameter int W = 8,
  localparam int RW = TAPS * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  sample_in,
  input  logic [RW-1:0] refs,
  output cnt_t          cnt
);
  logic [W-1:0] line_q [TAPS];
  logic [TAPS-1:0] hit;
  cnt_t sum_e, sum_f, sum_g;

  always_ff @(posedge clk) begin
    if (rst) line_q[0] <= '0;
    else     line_q[0] <= sample_in;
  end

  for (genvar k = 1; k < TAPS; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line_q[k] <= '0;
      else     line_q[k] <= line_q[k-1];
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_cmp
    corr_eq #(.W(W)) u_eq (
      .smp(line_q[k]), .ref_val(refs[k*W +: W]), .hit(hit[k])
    );
  end

  corr_add u_add_e (.a(cnt_t'(hit[3])), .b(cnt_t'(hit[2])), .s(sum_e));
  corr_add u_add_f (.a(sum_e),          .b(cnt_t'(hit[1])), .s(sum_f));
  corr_add u_add_g (.a(sum_f),          .b(cnt_t'(hit[0])), .s(sum_g));

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= sum_g;
  end

  // R5: a four-tap count never exceeds four.
  a_r5_plain_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= cnt_t'(TAPS));
endmodule

// File: rtl/corr_retimed.sv
// Retimed structure. Lags: cmp a=-1 b=-1 c=-2 d=-2, adders e=-2 f=-1 g=0, host 0.
// Resulting registers: input->a 0, a->b 1, b->c 0, c->d 1, a->g 1, e->f 1, f->g 1,
// all other internal edges 0, plus the shared output register.
// Reset loads the state equivalent to a plain shift line full of zero samples.
module corr_retimed
  import corr_pkg::*;
#(
  parameter int W = 8,
  localparam int RW = TAPS * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  sample_in,
  input  logic [RW-1:0] refs,
  input  logic [RW-1:0] ref_boot,
  output cnt_t          cnt
);
  logic [W-1:0] sa_q;   // sample register on edge a->b
  logic [W-1:0] sc_q;   // sample register on edge c->d
  logic         ma_q;   // match register on edge a->g
  cnt_t         e_q;    // partial sum register on edge e->f
  cnt_t         f_q;    // partial sum register on edge f->g
  logic [W-1:0] tap_smp [TAPS];
  logic [TAPS-1:0] hit;
  logic [TAPS-1:0] boot_z;
  cnt_t sum_e, sum_f, sum_g;
  cnt_t boot_e, boot_f;

  assign tap_smp[0] = sample_in;
  assign tap_smp[1] = sa_q;
  assign tap_smp[2] = sa_q;
  assign tap_smp[3] = sc_q;

  for (genvar k = 0; k < TAPS; k++) begin : g_cmp
    corr_eq #(.W(W)) u_eq (
      .smp(tap_smp[k]), .ref_val(refs[k*W +: W]), .hit(hit[k])
    );
    assign boot_z[k] = (ref_boot[k*W +: W] == '0);
  end

  corr_add u_add_e (.a(cnt_t'(hit[3])), .b(cnt_t'(hit[2])), .s(sum_e));
  corr_add u_add_f (.a(e_q),            .b(cnt_t'(hit[1])), .s(sum_f));
  corr_add u_add_g (.a(f_q),            .b(cnt_t'(ma_q)),   .s(sum_g));

  assign boot_e = cnt_t'(boot_z[3]) + cnt_t'(boot_z[2]);
  assign boot_f = boot_e + cnt_t'(boot_z[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_q <= '0;
      sc_q <= '0;
      ma_q <= boot_z[0];
      e_q  <= boot_e;
      f_q  <= boot_f;
      cnt  <= '0;
    end else begin
      sa_q <= sample_in;
      sc_q <= sa_q;
      ma_q <= hit[0];
      e_q  <= sum_e;
      f_q  <= sum_f;
      cnt  <= sum_g;
    end
  end

  // R5: the relocated adder chain still never exceeds four.
  a_r5_retimed_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= cnt_t'(TAPS));
endmodule

// File: rtl/corr_pair.sv
module corr_pair
  import corr_pkg::*;
#(
  parameter int W = 8,
  localparam int RW = TAPS * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  sample_in,
  input  logic [RW-1:0] ref_in,
  output logic [CNT_W-1:0] count_plain,
  output logic [CNT_W-1:0] count_retimed
);
  logic [RW-1:0] ref_q;

  corr_ref_bank #(.W(W)) u_bank (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ref_q(ref_q)
  );

  corr_plain #(.W(W)) u_plain (
    .clk(clk), .rst(rst), .sample_in(sample_in), .refs(ref_q),
    .cnt(count_plain)
  );

  corr_retimed #(.W(W)) u_retimed (
    .clk(clk), .rst(rst), .sample_in(sample_in), .refs(ref_q),
    .ref_boot(ref_in), .cnt(count_retimed)
  );

  // R4: both structures emit the same count every cycle out of reset.
  a_r4_versions_agree: assert property (@(posedge clk) disable iff (rst)
    count_plain == count_retimed);
endmodule

// File: tb/corr_pair_bench.sv
`timescale 1ns/1ps
module corr_pair_bench;
  localparam int W = 8;
  localparam int NV = 16;
  // Refs for the table: slot0=11 slot1=22 slot2=33 slot3=00
  localparam logic [W-1:0] VX [NV] = '{8'h44, 8'h11, 8'h22, 8'h33, 8'h00, 8'h33,
    8'h22, 8'h11, 8'h55, 8'h11, 8'h11, 8'h22, 8'h00, 8'hFF, 8'hFF, 8'hFF};
  localparam logic [2:0] VE [NV] = '{3'd1, 3'd1, 3'd2, 3'd1, 3'd1, 3'd0,
    3'd1, 3'd0, 3'd4, 3'd0, 3'd1, 3'd1, 3'd0, 3'd1, 3'd0, 3'd0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic [4*W-1:0] ref_in = '0;
  logic [2:0] count_plain, count_retimed;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] hist [4];
  logic [W-1:0] refm [4];

  always #2 clk = ~clk;

  corr_pair #(.W(W)) u_corr_pair (
    .clk(clk), .rst(rst), .sample_in(sample_in), .ref_in(ref_in),
    .count_plain(count_plain), .count_retimed(count_retimed)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_count();
    int n = 0;
    for (int k = 0; k < 4; k++) if (hist[k] == refm[k]) n++;
    return n;
  endfunction

  task automatic push_hist(input logic [W-1:0] x);
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
  endtask

  task automatic do_reset(input logic [4*W-1:0] refs);
    rst = 1'b1;
    ref_in = refs;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R1 plain in reset", count_plain, 0);
      check("R1 retimed in reset", count_retimed, 0);
    end
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      hist[k] = '0;
      refm[k] = refs[k*W +: W];
    end
  endtask

  task automatic step(input logic [W-1:0] x, input string tag, input int exp);
    sample_in = x;
    @(posedge clk); #1;
    check({tag, " plain"}, count_plain, exp);
    check("R4 retimed equals plain", count_retimed, count_plain);
    push_hist(x);
  endtask

  initial begin
    #1;
    do_reset({8'h00, 8'h33, 8'h22, 8'h11});
    // Table walk: R2 with zero history at start (R3), all-match at row 8 (R5)
    for (int i = 0; i < NV; i++) begin
      sample_in = VX[i];
      @(posedge clk); #1;
      check("R2/R3 table plain", count_plain, VE[i]);
      check("R4 table retimed", count_retimed, VE[i]);
      check("R2 model agrees", model_count(), VE[i]);
      push_hist(VX[i]);
    end
    // Biased random stream, ref_in scrambled every cycle (R6 ignored)
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x;
      ref_in = {$urandom, $urandom};
      if ($urandom_range(1, 0) == 1) x = refm[$urandom_range(3, 0)];
      else x = W'($urandom);
      step(x, "R2/R6 random", model_count());
      check("R5 range", int'(count_plain <= 3'd4), 1);
    end
    // Zero references: zero history matches all taps (R3, R5)
    do_reset('0);
    ref_in = {4{8'h5A}};
    step(8'h00, "R3 zero history all match", 4);
    step(8'h5A, "R6 ref_in ignored", 4);
    step(8'h5A, "R6 ref_in ignored", 3);
    step(8'h5A, "R6 ref_in ignored", 2);
    step(8'h5A, "R6 ref_in ignored", 1);
    step(8'h5A, "R5 no match", 0);
    // Reset mid-stream clears both counts (R1)
    do_reset({8'hA4, 8'hA3, 8'hA2, 8'hA1});
    step(8'hA1, "R1 after re-reset", 0);
    step(8'hA2, "R2 after re-reset", 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule